// File: doc/BRIEF.md
# Memory-Card Host Interrupt and DMA Request Router

This block sits inside a memory-card host controller. It keeps one pending flag and one mask bit for each of thirteen interrupt sources. From them it produces a single level-sensitive interrupt line for the CPU and two DMA request lines, one for receive and one for transmit. Peripheral logic raises pending flags with one-cycle set strobes. The same logic lowers them with one-cycle clear strobes, for example when FIFO data has been moved. Clock start and clock stop commands have their own inputs, which manage the clock-off flag directly.

A thin register wrapper decodes the bus. It writes the mask through a write-enable and data pair, and it reads the pending and mask state back through the `pend` and `mask` outputs. The wrapper also supplies a DMA-mode level. While that level is high, the two FIFO service sources are withheld from the CPU interrupt and appear instead on the DMA request lines.

Top module: `card_irq_router`

## Requirements
- R1: On reset every pending flag is 0, the mask is all ones (13'h1FFF), and `irq`, `dma_rx_req` and `dma_tx_req` are low.
- R2: Each bit of `evt_set` sets the pending flag at the same position on the next clock edge. The flag then holds until it is cleared.
- R3: Each bit of `evt_clr` clears the pending flag at the same position on the next clock edge. When a set and a clear for the same bit arrive in the same cycle, the set wins.
- R4: A cycle with `mask_we` high loads the mask from bits 12:0 of `mask_wdata`. Bits above 12 are ignored.
- R5: `irq` is high one cycle after a state in which some pending flag is 1 and its mask bit is 0. A mask bit of 1 disables its source.
- R6: While `dma_mode` is high, sources 5 (receive FIFO service) and 6 (transmit FIFO service) are treated as masked for `irq`, whatever the mask holds.
- R7: While `dma_mode` is high, `dma_rx_req` follows pending flag 5 and `dma_tx_req` follows pending flag 6, each one cycle later.
- R8: While `dma_mode` is low, both DMA request lines are low on the following cycle.
- R9: `clk_stop` sets pending flag 4 (clock off) and `clk_start` clears it. If both are high in the same cycle, the flag ends set.
- R10: The outputs are registered. A change to the pending flags, to the mask or to `dma_mode` reaches `irq` and the DMA lines one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 13 | Per-source set strobes |
| evt_clr | input | 13 | Per-source clear strobes |
| clk_start | input | 1 | Card clock start command (clears flag 4) |
| clk_stop | input | 1 | Card clock stop command (sets flag 4) |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 16 | Mask write data; only bits 12:0 are kept |
| dma_mode | input | 1 | Routes sources 5 and 6 to the DMA lines |
| pend | output | 13 | Pending flags, for readback |
| mask | output | 13 | Mask, for readback |
| irq | output | 1 | Level interrupt to the CPU |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The assertions assume the strobes are single-cycle pulses that are sampled only at clock edges. They also assume that `dma_mode` is a level which is stable between edges. The stimulus changes every input at the falling edge, one step per clock cycle, so each input holds for exactly one rising edge. The stimulus also places set and clear on the same bit in the same cycle, and stop and start in the same cycle, to exercise the two priority rules.

// File: rtl/card_irq_router.sv
module card_irq_router #(
  parameter int N_SRC     = 13,
  parameter int MASK_IN_W = 16,
  parameter int RX_IDX    = 5,
  parameter int TX_IDX    = 6,
  parameter int CKOFF_IDX = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     evt_set,
  input  logic [N_SRC-1:0]     evt_clr,
  input  logic                 clk_start,
  input  logic                 clk_stop,
  input  logic                 mask_we,
  input  logic [MASK_IN_W-1:0] mask_wdata,
  input  logic                 dma_mode,
  output logic [N_SRC-1:0]     pend,
  output logic [N_SRC-1:0]     mask,
  output logic                 irq,
  output logic                 dma_rx_req,
  output logic                 dma_tx_req
);
  localparam logic [N_SRC-1:0] FIFO_M  = (N_SRC'(1) << RX_IDX) | (N_SRC'(1) << TX_IDX);
  localparam logic [N_SRC-1:0] CKOFF_M = N_SRC'(1) << CKOFF_IDX;

  logic [N_SRC-1:0] set_all, clr_all, eff_mask;
  logic             unused_mask_hi;

  assign set_all  = evt_set | (clk_stop  ? CKOFF_M : '0);
  assign clr_all  = evt_clr | (clk_start ? CKOFF_M : '0);
  assign eff_mask = mask | (dma_mode ? FIFO_M : '0);
  assign unused_mask_hi = ^mask_wdata[MASK_IN_W-1:N_SRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '1;
    end else begin
      pend <= (pend & ~clr_all) | set_all;
      if (mask_we) mask <= mask_wdata[N_SRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      dma_rx_req <= 1'b0;
      dma_tx_req <= 1'b0;
    end else begin
      irq        <= |(pend & ~eff_mask);
      dma_rx_req <= dma_mode & pend[RX_IDX];
      dma_tx_req <= dma_mode & pend[TX_IDX];
    end
  end
endmodule

// File: rtl/card_irq_router_chk.sv
module card_irq_router_chk #(
  parameter int N_SRC     = 13,
  parameter int MASK_IN_W = 16,
  parameter int RX_IDX    = 5,
  parameter int TX_IDX    = 6,
  parameter int CKOFF_IDX = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_SRC-1:0]     evt_set,
  input logic [N_SRC-1:0]     evt_clr,
  input logic                 clk_start,
  input logic                 clk_stop,
  input logic                 mask_we,
  input logic [MASK_IN_W-1:0] mask_wdata,
  input logic                 dma_mode,
  input logic [N_SRC-1:0]     pend,
  input logic [N_SRC-1:0]     mask,
  input logic                 irq,
  input logic                 dma_rx_req,
  input logic                 dma_tx_req
);
  localparam logic [N_SRC-1:0] FIFO_M  = (N_SRC'(1) << RX_IDX) | (N_SRC'(1) << TX_IDX);
  localparam logic [N_SRC-1:0] CKOFF_M = N_SRC'(1) << CKOFF_IDX;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((pend & $past(evt_set)) == $past(evt_set))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_clr & ~evt_set & ~CKOFF_M) != '0) |=> ((pend & $past(evt_clr & ~evt_set & ~CKOFF_M)) == '0)); // R3
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(mask_wdata[N_SRC-1:0]))); // R4
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(pend) & ~($past(mask) | ($past(dma_mode) ? FIFO_M : '0))))); // R5
  AST_DMA_HIDES_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && ((pend & ~FIFO_M & ~mask) == '0)) |=> !irq); // R6
  AST_DMA_RX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |=> (dma_rx_req == $past(pend[RX_IDX]) && dma_tx_req == $past(pend[TX_IDX]))); // R7
  AST_DMA_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |=> (!dma_rx_req && !dma_tx_req)); // R8
  AST_CKOFF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> pend[CKOFF_IDX]); // R9
  AST_CKOFF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_start && !clk_stop && !evt_set[CKOFF_IDX]) |=> !pend[CKOFF_IDX]); // R9
endmodule

bind card_irq_router card_irq_router_chk #(
  .N_SRC(N_SRC), .MASK_IN_W(MASK_IN_W), .RX_IDX(RX_IDX), .TX_IDX(TX_IDX), .CKOFF_IDX(CKOFF_IDX)
) u_chk (.*);

// File: tb/sim_card_irq_router.sv
module sim_card_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] evt_set = '0, evt_clr = '0;
  logic        clk_start = 1'b0, clk_stop = 1'b0, mask_we = 1'b0, dma_mode = 1'b0;
  logic [15:0] mask_wdata = '0;
  logic [12:0] pend, mask;
  logic        irq, dma_rx_req, dma_tx_req;

  int checks = 0, errors = 0;
  logic [28:0] exp_q[$];
  string       tag_q[$];
  logic [12:0] mp, mm;
  bit          done = 0;

  always #10 clk = ~clk;

  card_irq_router u0 (.*);

  task automatic step(input logic [12:0] s, input logic [12:0] c, input logic st,
                      input logic sp, input logic we, input logic [15:0] wd,
                      input logic dm, input string tag);
    logic e_irq, e_rx, e_tx;
    logic [12:0] sa, ca;
    @(negedge clk);
    evt_set = s; evt_clr = c; clk_start = st; clk_stop = sp;
    mask_we = we; mask_wdata = wd; dma_mode = dm;
    e_irq = |(mp & ~(mm | (dm ? 13'h0060 : 13'h0)));
    e_rx  = dm & mp[5];
    e_tx  = dm & mp[6];
    sa = s | (sp ? 13'h0010 : 13'h0);
    ca = c | (st ? 13'h0010 : 13'h0);
    mp = (mp & ~ca) | sa;
    if (we) mm = wd[12:0];
    exp_q.push_back({mp, mm, e_irq, e_rx, e_tx});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    logic [28:0] e, a;
    string t;
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        a = {pend, mask, irq, dma_rx_req, dma_tx_req};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mp = '0; mm = 13'h1FFF;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({pend, mask, irq, dma_rx_req, dma_tx_req} !== {13'h0, 13'h1FFF, 3'b000}) begin
      errors++;
      $display("FAIL R1 actual %h expected %h", {pend, mask, irq, dma_rx_req, dma_tx_req}, {13'h0, 13'h1FFF, 3'b000});
    end
    @(negedge clk); rst_n = 1'b1;
    step('0, '0, 0, 0, 0, 16'h0, 0, "R1 idle after reset");
    step('0, '0, 0, 0, 1, 16'hE000, 0, "R4 upper bits ignored");
    step(13'h0001, '0, 0, 0, 0, 16'h0, 0, "R2 set bit0");
    step('0, '0, 0, 0, 0, 16'h0, 0, "R5 irq rises R10");
    step('0, 13'h0001, 0, 0, 0, 16'h0, 0, "R3 clear bit0");
    step('0, '0, 0, 0, 0, 16'h0, 0, "R5 irq falls");
    step(13'h0004, 13'h0004, 0, 0, 0, 16'h0, 0, "R3 set wins");
    step('0, '0, 0, 0, 1, 16'hF004, 0, "R4 mask bit2");
    step('0, '0, 0, 0, 0, 16'h0, 0, "R5 masked source quiet");
    step(13'h0060, '0, 0, 0, 0, 16'h0, 0, "R8 fifo bits dma off");
    step('0, '0, 0, 0, 0, 16'h0, 0, "R8 irq from fifo no dma");
    step('0, '0, 0, 0, 0, 16'h0, 1, "R6 dma mode on R10");
    step('0, '0, 0, 0, 0, 16'h0, 1, "R7 both dma lines");
    step('0, 13'h0020, 0, 0, 0, 16'h0, 1, "R7 clear rx");
    step('0, '0, 0, 0, 0, 16'h0, 1, "R7 rx drops");
    step('0, '0, 0, 1, 0, 16'h0, 1, "R9 clock stop");
    step('0, '0, 0, 0, 0, 16'h0, 1, "R9 clock off irq");
    step('0, '0, 1, 0, 0, 16'h0, 1, "R9 clock start");
    step('0, '0, 1, 1, 0, 16'h0, 1, "R9 start and stop");
    step('0, '0, 0, 0, 0, 16'h0, 0, "R8 dma off");
    step('0, 13'h1FFF, 0, 0, 1, 16'h1FFF, 0, "R3 clear all");
    step(13'h1A00, '0, 0, 0, 1, 16'h0DFF, 0, "R5 high sources");
    step('0, '0, 0, 0, 0, 16'h0, 0, "R5 bit9 unmasked");
    step('0, '0, 0, 0, 0, 16'h0, 0, "R2 flags hold");
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule